// File: doc/BRIEF.md
# Phased Multi-Channel PWM Generator

This block drives five independent pulse-width-modulated enable outputs from one reference clock. Each channel holds an 8-bit duty value, a two-bit phase code that shifts its on-window by a whole quarter of the period, and a prescale bit that halves the rate of its period counter. Configuration arrives over a small internal write-strobe bus. New channel settings are staged, and they reach the output only when that channel's period starts again, so a write in the middle of a period never shortens or stretches the pulse in progress.

A global synchronization option restarts every channel's period counter on the rising edge of a chip-select line. Several such blocks on one board can then run in phase with each other. The chip-select input and a separate stop input each pass through a two-stage synchronizer. The detected chip-select edge is also driven out as a single-cycle pulse. When the stop override is enabled, a high stop input forces channel 3 (the fourth output) on.

Top module: `phase_pwm5`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every `pwm_o` bit and `sync_pulse_o` are 0. Each channel then holds duty 0, phase 0 and no prescale, and both global options are off.
- R2: Each channel runs an 8-bit period counter of 256 steps. For a duty D from 1 to 254, the channel is high for exactly D of the 256 steps of each period. A duty of 0 keeps it low.
- R3: A duty of 255 keeps the channel high on every step, whatever its phase code.
- R4: Phase code p (bits [9:8]: 00, 01, 10, 11 give 0°, 90°, 180°, 270°) makes the channel high when (count − 64·p) mod 256 < D. Just after a restart, channel k with code k and D=64 is the only one of channels 0..3 high at count 64·k, and it stays high through count 64·k+63.
- R5: With prescale bit [10] set, the counter steps on every second clock, so one period lasts 512 clocks. The first prescaled step after a restart comes on the second clock.
- R6: A write to a channel's duty, phase or prescale has no effect until that channel's counter wraps from 255 to 0, or until a restart.
- R7: With sync-enable set, each detected rising edge of `cs_i` sets every channel counter to 0 and loads the staged settings on the clock edge that follows the pulse on `sync_pulse_o`.
- R8: With sync-enable clear, a rising edge of `cs_i` still produces `sync_pulse_o`, but the counters keep running undisturbed.
- R9: `sync_pulse_o` is high for exactly one clock for each rising edge of `cs_i`. It appears after the two-stage synchronizer.
- R10: With stop-enable set and the synchronized `stop_i` high, `pwm_o[3]` is forced high. With stop-enable clear, `stop_i` has no effect. No other channel is affected in either case.
- R11: At address 0, bit 0 is sync-enable and bit 1 is stop-enable. Address 1+i holds channel i's settings. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 11 | Write data: duty [7:0], phase [9:8], prescale [10] |
| cs_i | input | 1 | Chip-select level; its rising edge is the restart event |
| stop_i | input | 1 | Stop override request for channel 3 |
| pwm_o | output | 5 | PWM enables, one bit per channel |
| sync_pulse_o | output | 1 | One-cycle pulse per detected chip-select rising edge |

## Verification
Several duty mixes are loaded together: 0, 1, 64, 128 and 255. A count of high cycles over a full window shows the proportional compare and separates both saturating ends from the off-by-one cases. Four channels with phase codes 0 to 3 are checked at the quarter boundaries right after a restart. This tells a correct offset apart from a swapped code or a reversed subtraction. A mid-period duty write, a chip-select edge with sync disabled, and a prescaled channel measured over two half windows each probe a timing rule: staged loading, the restart gate, and the step rate. The stop input and writes to unused addresses are each toggled with the override enabled and disabled, to show that they act only where they are meant to.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    parameter int NUM_CH = 5;
    parameter int CNT_W  = 8;
    parameter int PH_W   = 2;

    typedef struct packed {
        logic             pre;
        logic [PH_W-1:0]  phase;
        logic [CNT_W-1:0] duty;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/pwm_bit_sync.sv
module pwm_bit_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM = pwm_pkg::NUM_CH,
    localparam int ADDR_W = $clog2(NUM + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [CFG_W-1:0]       wr_data_i,
    output logic                   sync_en_o,
    output logic                   stop_en_o,
    output chan_cfg_t [NUM-1:0]    cfg_o
);
    typedef struct packed {
        logic                sync_en;
        logic                stop_en;
        chan_cfg_t [NUM-1:0] cfg;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_addr_i == '0) begin
                st_d.sync_en = wr_data_i[0];
                st_d.stop_en = wr_data_i[1];
            end
            for (int i = 0; i < NUM; i++) begin
                if (wr_addr_i == ADDR_W'(i + 1)) st_d.cfg[i] = chan_cfg_t'(wr_data_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_en_o = st_q.sync_en;
    assign stop_en_o = st_q.stop_en;
    assign cfg_o     = st_q.cfg;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_i,
    input  logic             restart_i,
    input  chan_cfg_t        cfg_i,
    output logic [CNT_W-1:0] cnt_o,
    output chan_cfg_t        act_o,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        chan_cfg_t        act;
    } ch_state_t;

    ch_state_t        st_d, st_q;
    logic             adv;
    logic [CNT_W-1:0] rel;

    always_comb begin
        st_d = st_q;
        adv  = !st_q.act.pre || half_i;
        if (restart_i) begin
            st_d.cnt = '0;
            st_d.act = cfg_i;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX) st_d.act = cfg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rel   = st_q.cnt - {st_q.act.phase, {(CNT_W-PH_W){1'b0}}};
    assign pwm_o = (st_q.act.duty == CNT_MAX) || (rel < st_q.act.duty);
    assign cnt_o = st_q.cnt;
    assign act_o = st_q.act;
endmodule

// File: rtl/phase_pwm5.sv
module phase_pwm5
    import pwm_pkg::*;
#(
    parameter int NUM     = pwm_pkg::NUM_CH,
    parameter int STOP_CH = 3,
    localparam int ADDR_W = $clog2(NUM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    input  logic              cs_i,
    input  logic              stop_i,
    output logic [NUM-1:0]    pwm_o,
    output logic              sync_pulse_o
);
    typedef struct packed {
        logic half;
        logic cs_prev;
    } top_state_t;

    top_state_t              st_d, st_q;
    logic                    sync_en, stop_en;
    chan_cfg_t [NUM-1:0]     cfg_stage;
    chan_cfg_t [NUM-1:0]     cfg_act;
    logic [NUM-1:0][CNT_W-1:0] cnt_all;
    logic [NUM-1:0]          pwm_raw;
    logic                    cs_s, stop_s, restart;
    logic [CNT_W-1:0]        cnt0;
    logic                    pre0;
    logic [CNT_W-1:0]        duty0;

    pwm_regs #(.NUM(NUM)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .sync_en_o (sync_en),
        .stop_en_o (stop_en),
        .cfg_o     (cfg_stage)
    );

    pwm_bit_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, stop_i}),
        .q_o   ({cs_s, stop_s})
    );

    assign sync_pulse_o = cs_s && !st_q.cs_prev;
    assign restart      = sync_pulse_o && sync_en;

    always_comb begin
        st_d.cs_prev = cs_s;
        st_d.half    = restart ? 1'b0 : !st_q.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM; g++) begin : gen_ch
        pwm_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .half_i    (st_q.half),
            .restart_i (restart),
            .cfg_i     (cfg_stage[g]),
            .cnt_o     (cnt_all[g]),
            .act_o     (cfg_act[g]),
            .pwm_o     (pwm_raw[g])
        );
        if (g == STOP_CH) begin : gen_stop
            assign pwm_o[g] = pwm_raw[g] || (stop_en && stop_s);
        end else begin : gen_plain
            assign pwm_o[g] = pwm_raw[g];
        end
    end

    assign cnt0  = cnt_all[0];
    assign pre0  = cfg_act[0].pre;
    assign duty0 = cfg_act[0].duty;
endmodule

// File: rtl/phase_pwm5_chk.sv
module phase_pwm5_chk #(
    parameter int NUM     = 5,
    parameter int CNT_W   = 8,
    parameter int STOP_CH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_pulse_o,
    input logic             sync_en,
    input logic             stop_en,
    input logic             stop_s,
    input logic [NUM-1:0]   pwm_o,
    input logic [CNT_W-1:0] cnt0,
    input logic             pre0,
    input logic [CNT_W-1:0] duty0
);
    // R9
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |=> !sync_pulse_o);

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse_o && sync_en) |=> (cnt0 == '0));

    // R5
    full_rate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sync_pulse_o && sync_en) && !pre0) |=> (cnt0 == CNT_W'($past(cnt0) + 1'b1)));

    // R10
    stop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_en && stop_s) |-> pwm_o[STOP_CH]);

    // R2
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty0 == '0) |-> !pwm_o[0]);
endmodule

bind phase_pwm5 phase_pwm5_chk #(.NUM(NUM), .CNT_W(pwm_pkg::CNT_W), .STOP_CH(STOP_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_pulse_o (sync_pulse_o),
    .sync_en      (sync_en),
    .stop_en      (stop_en),
    .stop_s       (stop_s),
    .pwm_o        (pwm_o),
    .cnt0         (cnt0),
    .pre0         (pre0),
    .duty0        (duty0)
);

// File: tb/phase_pwm5_bench.sv
`timescale 1ns/1ps
module phase_pwm5_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [10:0] wr_data_i = '0;
    logic        cs_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [4:0]  pwm_o;
    logic        sync_pulse_o;

    int checks = 0;
    int fails  = 0;
    int elapsed = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    phase_pwm5 u_phase_pwm5 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .cs_i         (cs_i),
        .stop_i       (stop_i),
        .pwm_o        (pwm_o),
        .sync_pulse_o (sync_pulse_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            elapsed++;
        end
    endtask

    task automatic step_to(input int target);
        while (elapsed < target) step(1);
    endtask

    task automatic wr(input logic [2:0] a, input logic [10:0] d);
        wr_en_i   = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        step(1);
        wr_en_i   = 1'b0;
    endtask

    function automatic logic [10:0] cfg(input bit pre, input int ph, input int duty);
        return {pre, 2'(ph), 8'(duty)};
    endfunction

    // Raise chip select, wait for the pulse, land on the sample where count = 0.
    task automatic restart(input string req);
        bit seen = 0;
        cs_i = 1'b0;
        step(4);
        cs_i = 1'b1;
        for (int k = 0; k < 10 && !seen; k++) begin
            step(1);
            if (sync_pulse_o) seen = 1;
        end
        check(req, int'(seen), 1);
        @(posedge clk);
        @(negedge clk);
        cs_i = 1'b0;
        elapsed = 0;
    endtask

    task automatic count_high(input int ch, input int n, output int acc);
        acc = 0;
        for (int k = 0; k < n; k++) begin
            acc += int'(pwm_o[ch]);
            step(1);
        end
    endtask

    task automatic test_reset();
        int acc;
        check("R1 pwm after reset", int'(pwm_o), 0);
        check("R1 pulse after reset", int'(sync_pulse_o), 0);
        count_high(0, 300, acc);
        check("R2 default duty 0 stays low", acc, 0);
    endtask

    task automatic test_duty();
        int acc;
        wr(3'd0, 11'd1);
        wr(3'd1, cfg(0, 0, 64));
        wr(3'd2, cfg(0, 0, 0));
        wr(3'd3, cfg(0, 0, 255));
        wr(3'd4, cfg(0, 0, 128));
        wr(3'd5, cfg(0, 0, 1));
        restart("R7 restart pulse seen");
        step(20);
        count_high(0, 256, acc); check("R2 duty 64", acc, 64);
        count_high(1, 256, acc); check("R2 duty 0", acc, 0);
        count_high(2, 256, acc); check("R3 duty 255 full on", acc, 256);
        count_high(3, 256, acc); check("R2 duty 128", acc, 128);
        count_high(4, 256, acc); check("R2 duty 1", acc, 1);
        wr(3'd3, cfg(0, 2, 255));
        restart("R7 restart pulse seen");
        count_high(2, 256, acc); check("R3 duty 255 with phase", acc, 256);
    endtask

    task automatic test_phase();
        for (int c = 0; c < 4; c++) wr(3'(c + 1), cfg(0, c, 64));
        restart("R7 restart pulse seen");
        check("R4 R7 count 0 phase 0 only", int'(pwm_o[3:0]), 1);
        step_to(63);  check("R4 count 63 still phase 0", int'(pwm_o[3:0]), 1);
        step_to(64);  check("R4 count 64 phase 1", int'(pwm_o[3:0]), 2);
        step_to(127); check("R4 count 127 phase 1", int'(pwm_o[3:0]), 2);
        step_to(128); check("R4 count 128 phase 2", int'(pwm_o[3:0]), 4);
        step_to(192); check("R4 count 192 phase 3", int'(pwm_o[3:0]), 8);
        step_to(256); check("R4 wrap back to phase 0", int'(pwm_o[3:0]), 1);
    endtask

    task automatic test_prescale();
        int acc;
        wr(3'd1, cfg(0, 0, 64));
        wr(3'd5, cfg(1, 0, 64));
        restart("R7 restart pulse seen");
        count_high(4, 256, acc); check("R5 prescaled first half window", acc, 128);
        count_high(4, 256, acc); check("R5 prescaled second half window", acc, 0);
        count_high(0, 512, acc); check("R5 unscaled over 512", acc, 128);
        count_high(4, 512, acc); check("R5 prescaled over 512", acc, 128);
    endtask

    task automatic test_update();
        wr(3'd1, cfg(0, 0, 64));
        restart("R7 restart pulse seen");
        step_to(10);
        wr(3'd1, cfg(0, 0, 200));
        step_to(100);       check("R6 old duty kept mid period", int'(pwm_o[0]), 0);
        step_to(256 + 150); check("R6 new duty after wrap", int'(pwm_o[0]), 1);
        step_to(256 + 199); check("R6 new duty last high", int'(pwm_o[0]), 1);
        step_to(256 + 200); check("R6 new duty first low", int'(pwm_o[0]), 0);
    endtask

    task automatic test_nosync();
        bit seen = 0;
        wr(3'd1, cfg(0, 0, 64));
        restart("R7 restart pulse seen");
        wr(3'd0, 11'd0);
        step_to(100);
        cs_i = 1'b1;
        for (int k = 0; k < 10 && !seen; k++) begin
            step(1);
            if (sync_pulse_o) seen = 1;
        end
        check("R8 pulse with sync off", int'(seen), 1);
        step(1);
        check("R9 pulse lasts one cycle", int'(sync_pulse_o), 0);
        cs_i = 1'b0;
        step_to(256 + 5);
        check("R8 counter not restarted", int'(pwm_o[0]), 1);
        step_to(256 + 70);
        check("R8 counter phase kept", int'(pwm_o[0]), 0);
    endtask

    task automatic test_stop();
        wr(3'd0, 11'd1);
        wr(3'd3, cfg(0, 0, 0));
        wr(3'd4, cfg(0, 0, 0));
        restart("R7 restart pulse seen");
        stop_i = 1'b1;
        step(5);
        check("R10 stop ignored when disabled", int'(pwm_o[3]), 0);
        wr(3'd0, 11'd3);
        step(4);
        check("R10 stop forces channel 3", int'(pwm_o[3]), 1);
        check("R10 channel 2 unaffected", int'(pwm_o[2]), 0);
        stop_i = 1'b0;
        step(5);
        check("R10 release stop", int'(pwm_o[3]), 0);
    endtask

    task automatic test_badaddr();
        int acc;
        wr(3'd0, 11'd1);
        for (int c = 0; c < 5; c++) wr(3'(c + 1), cfg(0, 0, 0));
        wr(3'd6, 11'h7FF);
        wr(3'd7, 11'h7FF);
        restart("R11 sync still enabled");
        stop_i = 1'b1;
        acc = 0;
        for (int k = 0; k < 300; k++) begin
            acc += int'(pwm_o != 5'd0);
            step(1);
        end
        check("R11 unused addresses change nothing", acc, 0);
        stop_i = 1'b0;
    endtask

    initial begin : watchdog
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pwm in reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_duty();
        test_phase();
        test_prescale();
        test_update();
        test_nosync();
        test_stop();
        test_badaddr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule